// File: doc/BRIEF.md
# Flash Descriptor Readout Sequencer

This block serves the "report organisation" command of a flash controller. Software writes an opcode into a command register. When that opcode asks for the descriptor, the block steps through a fixed list of 32-bit words that describe the memory. Each read of the result register returns the current word and moves on to the next one. The list is built at elaboration from parameters: an interface identifier, the total size, the page size, the plane count with one size per plane, and the lock-region count with one size per region. Its length therefore depends on how many planes and lock regions the part has.

A ready flag tells software when the result register can be read. The flag drops for one cycle each time a command is taken and rises again on the next cycle. Once the whole list has been read out, the result register reads as zero until a new command arrives. Any other opcode ends the sequence. The bus wrapper, the flash array and the other commands sit outside this block.

Top module: `flash_desc_seq`

## Requirements
- R1: After reset `ready` is 1 and `rd_data` is 0.
- R2: A command write with `ready` high is accepted. `ready` is 0 in the cycle after acceptance and 1 in the cycle after that. A command write while `ready` is 0 is ignored.
- R3: Opcode 8'h00 starts the descriptor at word 0. Words 0 to 3 are, in order, the interface identifier, the total size in bytes, the page size in bytes and the plane count N.
- R4: Words 4 to 3+N hold the byte size of plane 0 through plane N-1.
- R5: Word 4+N holds the lock-region count L. Words 5+N to 4+N+L hold the byte sizes of lock regions 0 to L-1, in that order.
- R6: `rd_data` shows the current word. Each `rd_strobe` sampled with `ready` high moves to the next word, which appears in the following cycle.
- R7: Once all 5+N+L words have been passed, `rd_data` is 0 for every further read until the next accepted command.
- R8: An accepted opcode other than 8'h00 ends the sequence, so `rd_data` reads 0. A later 8'h00 restarts from word 0.
- R9: An `rd_strobe` while `ready` is 0 does not advance the word index.
- R10: Before any command has been accepted, `rd_data` is 0 even when reads are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_op | input | 8 | Opcode written with `cmd_wr` |
| rd_strobe | input | 1 | Result register read strobe |
| rd_data | output | 32 | Result register contents |
| ready | output | 1 | Command done / result valid flag |

## Verification
The main readout is tried with a single full pass that runs past the end of the list. This separates the fixed header words, the plane area, the lock area and the zero tail, so an index that is off by one, or a count that ignores N or L, shows up as a wrong word at a known position. A second case restarts the list in the middle of a pass with a new get-descriptor command. A third case sends a different opcode, which tells a true reset of the index apart from a sequence that only looks finished. Two more cases issue a read and a command inside the one-cycle window where `ready` is low, to show that both are ignored there and not queued.

// File: rtl/flash_desc_pkg.sv
package flash_desc_pkg;
  localparam int DW = 32;
  localparam int OPW = 8;
  localparam logic [OPW-1:0] OP_GET_DESC = 8'h00;

  // header words, plane sizes, lock count word, lock sizes
  function automatic int unsigned desc_len(input int unsigned planes, input int unsigned locks);
    return 4 + planes + 1 + locks;
  endfunction
endpackage

// File: rtl/flash_desc_rom.sv
module flash_desc_rom
  import flash_desc_pkg::*;
#(
  parameter logic [DW-1:0]        ID_WORD     = 32'h0000_0001,
  parameter logic [DW-1:0]        TOTAL_BYTES = 32'h0010_0000,
  parameter logic [DW-1:0]        PAGE_BYTES  = 32'd512,
  parameter int unsigned          NPLANES     = 2,
  parameter logic [NPLANES*DW-1:0] PLANE_BYTES = {NPLANES{32'h0008_0000}},
  parameter int unsigned          NLOCKS      = 4,
  parameter logic [NLOCKS*DW-1:0]  LOCK_BYTES  = {NLOCKS{32'h0004_0000}},
  parameter int unsigned          IW          = 4
) (
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] word
);
  localparam int unsigned PLANE_BASE = 4;
  localparam int unsigned LCNT_POS   = PLANE_BASE + NPLANES;
  localparam int unsigned LOCK_BASE  = LCNT_POS + 1;
  localparam int unsigned NWORDS     = desc_len(NPLANES, NLOCKS);

  function automatic logic [DW-1:0] pick(input int unsigned k);
    logic [DW-1:0] w;
    w = '0;
    if (k == 0)               w = ID_WORD;
    else if (k == 1)          w = TOTAL_BYTES;
    else if (k == 2)          w = PAGE_BYTES;
    else if (k == 3)          w = DW'(NPLANES);
    else if (k < LCNT_POS)    w = PLANE_BYTES[(k-PLANE_BASE)*DW +: DW];
    else if (k == LCNT_POS)   w = DW'(NLOCKS);
    else if (k < NWORDS)      w = LOCK_BYTES[(k-LOCK_BASE)*DW +: DW];
    return w;
  endfunction

  always_comb word = pick(int'(idx));
endmodule

// File: rtl/flash_desc_cmd.sv
module flash_desc_cmd
  import flash_desc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [OPW-1:0] cmd_op,
  output logic           ready,
  output logic           cmd_acc,
  output logic           active
);
  logic ready_q, active_q;

  assign cmd_acc = cmd_wr && ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b1;
      active_q <= 1'b0;
    end else begin
      ready_q <= !cmd_acc;
      if (cmd_acc) active_q <= (cmd_op == OP_GET_DESC);
    end
  end

  assign ready  = ready_q;
  assign active = active_q;
endmodule

// File: rtl/flash_desc_index.sv
module flash_desc_index #(
  parameter int unsigned NWORDS = 11,
  parameter int unsigned IW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_acc,
  input  logic          rd_strobe,
  input  logic          ready,
  input  logic          active,
  output logic [IW-1:0] idx,
  output logic          at_end,
  output logic          rd_adv
);
  logic [IW-1:0] idx_q;

  assign at_end = (idx_q == IW'(NWORDS));
  assign rd_adv = rd_strobe && ready && active && !at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (cmd_acc) idx_q <= '0;
    else if (rd_adv)  idx_q <= idx_q + 1'b1;
  end

  assign idx = idx_q;
endmodule

// File: rtl/flash_desc_seq.sv
module flash_desc_seq
  import flash_desc_pkg::*;
#(
  parameter logic [31:0]           ID_WORD     = 32'h0000_0001,
  parameter logic [31:0]           TOTAL_BYTES = 32'h0010_0000,
  parameter logic [31:0]           PAGE_BYTES  = 32'd512,
  parameter int unsigned           NPLANES     = 2,
  parameter logic [NPLANES*32-1:0] PLANE_BYTES = {NPLANES{32'h0008_0000}},
  parameter int unsigned           NLOCKS      = 4,
  parameter logic [NLOCKS*32-1:0]  LOCK_BYTES  = {NLOCKS{32'h0004_0000}}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_op,
  input  logic        rd_strobe,
  output logic [31:0] rd_data,
  output logic        ready
);
  localparam int unsigned NWORDS = desc_len(NPLANES, NLOCKS);
  localparam int unsigned IW     = $clog2(NWORDS + 1);

  logic          cmd_acc, active, at_end, rd_adv;
  logic [IW-1:0] idx;
  logic [31:0]   rom_word;

  flash_desc_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .ready(ready), .cmd_acc(cmd_acc), .active(active)
  );

  flash_desc_index #(.NWORDS(NWORDS), .IW(IW)) u_idx (
    .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc), .rd_strobe(rd_strobe),
    .ready(ready), .active(active), .idx(idx), .at_end(at_end), .rd_adv(rd_adv)
  );

  flash_desc_rom #(
    .ID_WORD(ID_WORD), .TOTAL_BYTES(TOTAL_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .NPLANES(NPLANES), .PLANE_BYTES(PLANE_BYTES),
    .NLOCKS(NLOCKS), .LOCK_BYTES(LOCK_BYTES), .IW(IW)
  ) u_rom (
    .idx(idx), .word(rom_word)
  );

  assign rd_data = (active && !at_end) ? rom_word : '0;
endmodule

// File: rtl/flash_desc_seq_chk.sv
module flash_desc_seq_chk #(
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic          ready,
  input logic          cmd_acc,
  input logic          rd_adv,
  input logic          at_end,
  input logic [IW-1:0] idx,
  input logic [31:0]   rd_data
);
  // R2
  acc_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> !ready);
  // R2
  ready_low_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);
  // R9
  idle_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(idx));
  // R6
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !cmd_acc) |=> (idx == $past(idx) + 1'b1));
  // R7
  end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !cmd_acc) |=> (at_end && rd_data == '0));
  // R8
  acc_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> (idx == '0));
endmodule

bind flash_desc_seq flash_desc_seq_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .ready(ready), .cmd_acc(cmd_acc),
  .rd_adv(rd_adv), .at_end(at_end), .idx(idx), .rd_data(rd_data)
);

// File: tb/flash_desc_seq_bench.sv
module flash_desc_seq_bench;
  localparam logic [31:0] B_ID    = 32'h1A2B_0001;
  localparam logic [31:0] B_TOTAL = 32'h0010_0000;
  localparam logic [31:0] B_PAGE  = 32'd512;
  localparam int          B_N     = 2;
  localparam int          B_L     = 4;
  localparam logic [B_N*32-1:0] B_PLANES = {32'h0009_0000, 32'h0007_0000};
  localparam logic [B_L*32-1:0] B_LOCKS  = {32'h0004_0000, 32'h0006_0000, 32'h0004_0000, 32'h0002_0000};
  localparam int B_WORDS = 4 + B_N + 1 + B_L;

  logic clk = 0, rst_n = 0, cmd_wr = 0, rd_strobe = 0;
  logic [7:0]  cmd_op = 8'h00;
  logic [31:0] rd_data;
  logic        ready;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_desc_seq #(
    .ID_WORD(B_ID), .TOTAL_BYTES(B_TOTAL), .PAGE_BYTES(B_PAGE),
    .NPLANES(B_N), .PLANE_BYTES(B_PLANES), .NLOCKS(B_L), .LOCK_BYTES(B_LOCKS)
  ) u_flash_desc_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .ready(ready)
  );

  // expected word by position, built from the list layout
  function automatic logic [31:0] expect_word(input int k);
    if (k < 4) begin
      case (k)
        0: return B_ID;
        1: return B_TOTAL;
        2: return B_PAGE;
        default: return 32'(B_N);
      endcase
    end
    if (k - 4 < B_N) return B_PLANES[(k-4)*32 +: 32];
    if (k == 4 + B_N) return 32'(B_L);
    if (k - 5 - B_N < B_L) return B_LOCKS[(k-5-B_N)*32 +: 32];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op);
    @(negedge clk); cmd_wr = 1; cmd_op = op;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic read_one(input string tag, input logic [31:0] exp);
    @(negedge clk);
    check(tag, rd_data, exp);
    rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready", {31'b0, ready}, 32'h1);
    check("R1 data", rd_data, 32'h0);
    read_one("R10 read before command", 32'h0);
    read_one("R10 second read", 32'h0);
  endtask

  task automatic t_ready_pulse;
    @(negedge clk); cmd_wr = 1; cmd_op = 8'h00;
    @(negedge clk); cmd_wr = 1; cmd_op = 8'h03;
    check("R2 ready low after accept", {31'b0, ready}, 32'h0);
    @(negedge clk); cmd_wr = 0;
    check("R2 ready back high", {31'b0, ready}, 32'h1);
    check("R2 ignored opcode, word0", rd_data, B_ID);
  endtask

  task automatic t_full_pass;
    issue(8'h00);
    for (int k = 0; k < B_WORDS; k++) begin
      if (k < 4)           read_one("R3 header word", expect_word(k));
      else if (k < 4+B_N)  read_one("R4 plane size", expect_word(k));
      else                 read_one("R5 lock info", expect_word(k));
    end
    for (int k = 0; k < 3; k++) read_one("R7 past end", 32'h0);
  endtask

  task automatic t_restart;
    issue(8'h00);
    read_one("R6 word0", B_ID);
    read_one("R6 word1", B_TOTAL);
    issue(8'h00);
    read_one("R8 restart word0", B_ID);
    read_one("R6 word1 again", B_TOTAL);
  endtask

  task automatic t_other_op;
    issue(8'h00);
    read_one("R6 word0", B_ID);
    issue(8'h05);
    read_one("R8 other opcode data", 32'h0);
    read_one("R8 other opcode data 2", 32'h0);
    issue(8'h00);
    read_one("R8 getd after other", B_ID);
  endtask

  task automatic t_read_while_busy;
    @(negedge clk); cmd_wr = 1; cmd_op = 8'h00;
    @(negedge clk); cmd_wr = 0; rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
    check("R9 read in busy cycle ignored", rd_data, B_ID);
    read_one("R9 then word0", B_ID);
    read_one("R9 then word1", B_TOTAL);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ready_pulse();
        t_full_pass();
        t_restart();
        t_other_op();
        t_read_while_busy();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule